// File: doc/BRIEF.md
# Line-Bounded Read Burst Splitter

This block accepts a read request made of a start address and a count of 32-bit words. It turns that request into one or more read-address bursts for a 64-bit AXI port. No burst crosses a 32-byte line boundary, so a request that touches one line yields one burst, a request that spans two lines yields two, and a request that spans three lines yields three. Every burst uses the incrementing burst type with a doubleword transfer size. Its length is set by the number of doublewords that the burst's share of the request touches inside its line.

The requester presents a request on a valid/ready pair. The block then issues the bursts in ascending address order over the AR valid/ready handshake. One cycle after the last burst is accepted, it raises a single-cycle done pulse. A new request is taken only when the block is idle again.

Top module: `line_burst_splitter`

## Requirements
- R1: No burst crosses a line: for every presented burst, the doubleword index of ar_addr within its 32-byte line, ar_addr[4:3], plus ar_len is at most 3.
- R2: A request inside one line gives one burst, a request crossing one line boundary gives two, and a request crossing two boundaries gives three (for example, 16 words from 0x101C give three bursts).
- R3: Each burst's beat count is the number of doublewords its segment touches in the line, and ar_len is that count minus one (6 words from 0x1008 give ar_len 2).
- R4: Every burst has ar_burst = 2'b01 (incrementing) and ar_size = 3'b011 (8 bytes).
- R5: The first burst's address is the word-aligned start address (bits [1:0] cleared). Each later burst starts at the next 32-byte line boundary, so addresses ascend.
- R6: While ar_valid is high and ar_ready is low, ar_valid stays high and ar_addr and ar_len hold their values.
- R7: done is high for exactly one cycle, in the cycle after the handshake of the final burst, and at no other time.
- R8: req_ready is high only while no burst is pending. A request presented while bursts are pending is ignored and does not alter the bursts in flight.
- R9: After reset, ar_valid and done are low and req_ready is high.
- R10: An accepted request presents its first burst in the next cycle. A word count of 0 is treated as 1, and a count above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 32 | Start byte address, word aligned |
| req_words | input | 5 | Number of 32-bit words, 1 to 16 |
| ar_valid | output | 1 | Burst address valid |
| ar_ready | input | 1 | Burst address accepted by the port |
| ar_addr | output | 32 | Burst start address |
| ar_burst | output | 2 | Burst type, always incrementing |
| ar_size | output | 3 | Transfer size, always 8 bytes |
| ar_len | output | 8 | Beats in the burst minus one |
| done | output | 1 | Single-cycle pulse after the last burst is taken |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 32-byte lines, an 8-byte port and a 16-word ceiling. With these values a single request can reach all three burst counts, including a full four-beat burst in the middle of a three-burst split. The start offsets are chosen to put segments at the first and last doubleword of a line. A 16-word request starting in the last word of a line drives the widest case. Stalls on ar_ready and requests presented while busy exercise the hold and ignore rules.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam logic [1:0] BURST_INCR = 2'b01;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } lbs_state_e;

  function automatic logic [2:0] size_code(input int bytes);
    return 3'($clog2(bytes));
  endfunction
endpackage

// File: rtl/lbs_req_span.sv
module lbs_req_span #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 5,
  parameter int WORD_BYTES = 4,
  parameter int MAX_WORDS  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  words,
  output logic [ADDR_W-1:0] start,
  output logic [ADDR_W-1:0] stop
);
  localparam int WLSB = $clog2(WORD_BYTES);

  logic [CNT_W-1:0] words_c;

  always_comb begin
    if (words == '0)
      words_c = CNT_W'(1);
    else if (int'(words) > MAX_WORDS)
      words_c = CNT_W'(MAX_WORDS);
    else
      words_c = words;
  end

  assign start = {addr[ADDR_W-1:WLSB], {WLSB{1'b0}}};
  assign stop  = start + (ADDR_W'(words_c) << WLSB);
endmodule

// File: rtl/lbs_seg_calc.sv
module lbs_seg_calc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BUS_BYTES  = 8,
  parameter int LEN_W      = 8
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] stop,
  output logic [ADDR_W-1:0] next_line,
  output logic [LEN_W-1:0]  len,
  output logic              last
);
  localparam int LLSB = $clog2(LINE_BYTES);
  localparam int BLSB = $clog2(BUS_BYTES);
  localparam int IDXW = LLSB - BLSB;

  logic [ADDR_W-1:0] seg_end;
  logic [ADDR_W-1:0] seg_tail;
  logic [IDXW-1:0]   beats_m1;

  assign next_line = {cur[ADDR_W-1:LLSB] + 1'b1, {LLSB{1'b0}}};
  assign last      = (stop <= next_line);
  assign seg_end   = last ? stop : next_line;
  assign seg_tail  = seg_end - 1'b1;
  assign beats_m1  = seg_tail[LLSB-1:BLSB] - cur[LLSB-1:BLSB];
  assign len       = LEN_W'(beats_m1);
endmodule

// File: rtl/line_burst_splitter.sv
module line_burst_splitter
  import lbs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 5,
  parameter int WORD_BYTES = 4,
  parameter int MAX_WORDS  = 16,
  parameter int LINE_BYTES = 32,
  parameter int BUS_BYTES  = 8,
  parameter int LEN_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_words,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [1:0]        ar_burst,
  output logic [2:0]        ar_size,
  output logic [LEN_W-1:0]  ar_len,
  output logic              done
);
  lbs_state_e        state_q;
  logic [ADDR_W-1:0] stop_q, next_q;
  logic              last_q;

  logic [ADDR_W-1:0] req_start, req_stop;
  logic [ADDR_W-1:0] calc_cur, calc_stop, calc_next;
  logic [LEN_W-1:0]  calc_len;
  logic              calc_last;

  lbs_req_span #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .WORD_BYTES(WORD_BYTES), .MAX_WORDS(MAX_WORDS)
  ) u_span (
    .addr(req_addr), .words(req_words),
    .start(req_start), .stop(req_stop)
  );

  assign calc_cur  = (state_q == ST_IDLE) ? req_start : next_q;
  assign calc_stop = (state_q == ST_IDLE) ? req_stop  : stop_q;

  lbs_seg_calc #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .BUS_BYTES(BUS_BYTES), .LEN_W(LEN_W)
  ) u_seg (
    .cur(calc_cur), .stop(calc_stop),
    .next_line(calc_next), .len(calc_len), .last(calc_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ar_valid <= 1'b0;
      ar_addr  <= '0;
      ar_len   <= '0;
      stop_q   <= '0;
      next_q   <= '0;
      last_q   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q  <= ST_ISSUE;
            ar_valid <= 1'b1;
            ar_addr  <= calc_cur;
            ar_len   <= calc_len;
            next_q   <= calc_next;
            last_q   <= calc_last;
            stop_q   <= req_stop;
          end
        end
        default: begin
          if (ar_ready) begin
            if (last_q) begin
              state_q  <= ST_IDLE;
              ar_valid <= 1'b0;
              done     <= 1'b1;
            end else begin
              ar_addr <= calc_cur;
              ar_len  <= calc_len;
              next_q  <= calc_next;
              last_q  <= calc_last;
            end
          end
        end
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign ar_burst  = BURST_INCR;
  assign ar_size   = size_code(BUS_BYTES);
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BUS_BYTES  = 8,
  parameter int LEN_W      = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ADDR_W-1:0] ar_addr,
  input logic [1:0]        ar_burst,
  input logic [2:0]        ar_size,
  input logic [LEN_W-1:0]  ar_len,
  input logic              done
);
  localparam int LLSB = $clog2(LINE_BYTES);
  localparam int BLSB = $clog2(BUS_BYTES);
  localparam int BPL  = LINE_BYTES / BUS_BYTES;

  AST_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> (int'(ar_addr[LLSB-1:BLSB]) + int'(ar_len)) < BPL); // R1

  AST_FIXED_KIND: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> (ar_burst == 2'b01 && ar_size == 3'($clog2(BUS_BYTES)))); // R4

  AST_LATER_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ($past(ar_valid && ar_ready) && ar_valid) |-> (ar_addr[LLSB-1:0] == '0)); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr) && $stable(ar_len))); // R6

  AST_DONE_AFTER_HS: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(ar_valid && ar_ready) && !ar_valid)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
    ar_valid |-> !req_ready); // R8
endmodule

bind line_burst_splitter lbs_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
  .BUS_BYTES(BUS_BYTES), .LEN_W(LEN_W)
) u_lbs_checker (
  .clk(clk), .rst(rst), .req_ready(req_ready),
  .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
  .ar_burst(ar_burst), .ar_size(ar_size), .ar_len(ar_len), .done(done)
);

// File: tb/sim_line_burst_splitter.sv
`timescale 1ns/1ps
module sim_line_burst_splitter;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [4:0]  req_words;
  logic        ar_valid;
  logic        ar_ready;
  logic [31:0] ar_addr;
  logic [1:0]  ar_burst;
  logic [2:0]  ar_size;
  logic [7:0]  ar_len;
  logic        done;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [31:0] exp_addr [0:2];
  int          exp_len  [0:2];

  always #2 clk = ~clk;

  line_burst_splitter u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_words(req_words), .ar_valid(ar_valid),
    .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_burst(ar_burst),
    .ar_size(ar_size), .ar_len(ar_len), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // Present one request, then take its bursts with `stall` wait cycles each.
  // When `poke` is set, a different request is held on the input while stalled.
  task automatic run_req(input string tag, input logic [31:0] a, input int w,
                         input int nb, input int stall, input bit poke);
    @(negedge clk);
    chk(req_ready, "R9", {tag, " ready before request"}, req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_words = 5'(w);
    @(negedge clk);
    req_valid = 1'b0;
    chk(ar_valid, "R10", {tag, " first burst next cycle"}, ar_valid, 1);
    for (int k = 0; k < nb; k++) begin
      for (int s = 0; s < stall; s++) begin
        if (poke) begin
          req_valid = 1'b1; req_addr = 32'h0000_7F00; req_words = 5'd3;
        end
        chk(!req_ready, "R8", {tag, " busy not ready"}, req_ready, 0);
        @(negedge clk);
        chk(ar_valid && ar_addr == exp_addr[k], "R6", {tag, " held addr"},
            ar_addr, exp_addr[k]);
      end
      req_valid = 1'b0;
      chk(ar_valid, "R2", {tag, " burst present"}, ar_valid, 1);
      chk(ar_addr == exp_addr[k], "R5", {tag, " burst addr"}, ar_addr, exp_addr[k]);
      chk(int'(ar_len) == exp_len[k], "R3", {tag, " burst len"}, ar_len, exp_len[k]);
      chk(ar_burst == 2'b01 && ar_size == 3'b011, "R4", {tag, " burst kind"},
          {ar_burst, ar_size}, 5'b01011);
      chk(!done, "R7", {tag, " no early done"}, done, 0);
      ar_ready = 1'b1;
      @(negedge clk);
      ar_ready = 1'b0;
      if (k == nb - 1) begin
        chk(!ar_valid, "R2", {tag, " no extra burst"}, ar_valid, 0);
        chk(done, "R7", {tag, " done after last"}, done, 1);
        chk(req_ready, "R8", {tag, " ready again"}, req_ready, 1);
      end
    end
    @(negedge clk);
    chk(!done, "R7", {tag, " done one cycle"}, done, 0);
    chk(!ar_valid, "R8", {tag, " poke ignored"}, ar_valid, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_words = '0; ar_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!ar_valid, "R9", "reset ar_valid", ar_valid, 0);
    chk(!done, "R9", "reset done", done, 0);
    chk(req_ready, "R9", "reset req_ready", req_ready, 1);
  endtask

  task automatic t_single_line;   // R2 R3: 6 words at 0x1008
    exp_addr[0] = 32'h1008; exp_len[0] = 2;
    run_req("one-line", 32'h1008, 6, 1, 0, 0);
  endtask

  task automatic t_two_lines;     // R2 R5: one crossing
    exp_addr[0] = 32'h1010; exp_len[0] = 1;
    exp_addr[1] = 32'h1020; exp_len[1] = 0;
    run_req("two-line", 32'h1010, 6, 2, 1, 0);
  endtask

  task automatic t_three_lines;   // R1 R2: two crossings, widest request
    exp_addr[0] = 32'h101C; exp_len[0] = 0;
    exp_addr[1] = 32'h1020; exp_len[1] = 3;
    exp_addr[2] = 32'h1040; exp_len[2] = 3;
    run_req("three-line", 32'h101C, 16, 3, 2, 0);
  endtask

  task automatic t_aligned_full;  // R1 R3: 16 aligned words
    exp_addr[0] = 32'h2000; exp_len[0] = 3;
    exp_addr[1] = 32'h2020; exp_len[1] = 3;
    run_req("aligned16", 32'h2000, 16, 2, 0, 0);
  endtask

  task automatic t_small;         // R3 R5 R10: one word, odd word, unaligned bits
    exp_addr[0] = 32'h3004; exp_len[0] = 0;
    run_req("one-word", 32'h3006, 1, 1, 0, 0);
    exp_addr[0] = 32'h301C; exp_len[0] = 0;
    exp_addr[1] = 32'h3020; exp_len[1] = 0;
    run_req("two-word-cross", 32'h301C, 2, 2, 0, 0);
  endtask

  task automatic t_busy_poke;     // R6 R8: request offered while stalled
    exp_addr[0] = 32'h4018; exp_len[0] = 0;
    exp_addr[1] = 32'h4020; exp_len[1] = 0;
    run_req("busy-poke", 32'h4018, 4, 2, 3, 1);
  endtask

  task automatic t_clamp;         // R10: zero count treated as one word
    exp_addr[0] = 32'h5010; exp_len[0] = 0;
    run_req("zero-count", 32'h5010, 0, 1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_single_line();
    t_two_lines();
    t_three_lines();
    t_aligned_full();
    t_small();
    t_busy_poke();
    t_clamp();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule